// File: doc/BRIEF.md
# Clock Output Stop and Power-Down Controller

This block sits between a set of free-running clock sources and the clock output pins of a clock generator. The sources are a CPU clock, a PCI-rate clock, a 48 MHz clock, a selectable 48/24 MHz clock and the crystal reference. Three asynchronous, active-low controls decide which outputs toggle: one stops the CPU pair, one stops the PCI group, and one puts the whole generator into power down. The free-running PCI output and the fixed-rate outputs keep running through either stop request. Only power down silences them.

A small sequencer runs on the PCI-rate clock and resynchronises every control. Each output group has its own gate cell in its own clock domain. The gate cell resynchronises its enable with two flops and moves the gate only on the falling clock edge. A stopped output therefore always parks low, and the first pulse after a restart is a whole high phase. On power down the sequencer closes every gate and waits a drain interval, then drops the oscillator and VCO enables. On leaving power down, and after reset, it keeps every output low until a settling counter on the reference clock has expired.

Top module: `clkctl_top`

## Requirements
- R1: While the power-down control is low, the controller reaches state DOWN (code 4). In that state every clock output is low and both oscillator and VCO enables are 0, whatever the two stop controls do.
- R2: With the CPU-stop control low and power down high, both CPU outputs stay low. The PCI group, free-running PCI, 48 MHz, 48/24 MHz and reference outputs keep toggling, and the state reads CPU_STOPPED (code 1).
- R3: With the PCI-stop control low and power down high, the PCI group outputs stay low. The free-running PCI output and the CPU outputs keep toggling, and the state reads PCI_STOPPED (code 2).
- R4: With both stop controls low, both the CPU and PCI groups are low and the state reports PCI_STOPPED (code 2), which takes priority over CPU_STOPPED. With both stop controls high, the state reads RUN (code 0) and all outputs toggle.
- R5: A gate opens and closes only while its clock is low. Every high pulse on a CPU or PCI output therefore lasts a full half period: no runt pulse at stop or restart.
- R6: A CPU-stop edge reaches the CPU outputs after three PCI-clock edges (synchronisation and sequencer) plus 2 to 3 CPU clock periods. So the outputs still toggle during the first 30 time units after the edge and have changed state within 100 time units.
- R7: On a falling power-down control, the state passes through POWERING_DOWN (code 3) with the oscillator enable still 1. Every output is already low when the oscillator and VCO enables fall.
- R8: After reset, and after power down returns high, the state is POWERING_UP (code 5) with both enables at 1 and all outputs low. It stays there for at least SETTLE_CYCLES reference-clock cycles before normal running resumes.
- R9: Right after reset release the state is POWERING_UP (code 5), both enables are 1 and every clock output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu_i | input | 1 | CPU clock source |
| clk_pci_i | input | 1 | PCI-rate clock source; also clocks the sequencer |
| clk_48_i | input | 1 | Fixed 48 MHz source |
| clk_48_24_i | input | 1 | Selected 48/24 MHz source |
| clk_ref_i | input | 1 | Crystal reference source; clocks the settling counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Asynchronous CPU-group stop, active low |
| pci_stop_n | input | 1 | Asynchronous PCI-group stop, active low |
| pwr_dn_n | input | 1 | Asynchronous power-down request, active low |
| cpu_clk_o | output | NUM_CPU | Gated CPU clocks |
| pci_clk_o | output | NUM_PCI | Gated PCI group clocks |
| pcif_clk_o | output | 1 | Free-running PCI clock, stopped only by power down |
| clk48_o | output | 1 | Gated 48 MHz clock |
| clk48_24_o | output | 1 | Gated 48/24 MHz clock |
| ref_clk_o | output | NUM_REF | Gated reference clocks |
| osc_en_o | output | 1 | Oscillator enable |
| vco_en_o | output | 1 | VCO enable |
| state_o | output | 3 | Controller state code |

## Verification
A sequencer stuck in the wrong state shows on state_o one PCI clock after the fault. Within about three of the slowest output periods it shows as a group that toggles when it should be parked, or that is silent when it should run. An enable that drops too early shows as an output that was still high when the oscillator enable fell. A settling counter that expires early shows as POWERING_UP ending before SETTLE_CYCLES reference periods. A gate that moves on the wrong edge shows as a high pulse shorter than the half period of its clock on the first cycle after a stop or restart.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    typedef enum logic [2:0] {
        ST_RUN        = 3'd0,
        ST_CPU_OFF    = 3'd1,
        ST_PCI_OFF    = 3'd2,
        ST_GOING_DOWN = 3'd3,
        ST_DOWN       = 3'd4,
        ST_WAKING     = 3'd5
    } pm_state_e;

endpackage

// File: rtl/clkctl_gate.sv
// Glitch-free gate for one output group. The enable is resynchronised on
// rising edges and the gate moves on the falling edge, so the output can
// only open or close while the source clock is low.
module clkctl_gate #(
    parameter int WIDTH = 1
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic             en_i,
    output logic [WIDTH-1:0] clk_o,
    output logic             on_o
);

    logic [1:0] sync_d, sync_q;
    logic       on_d, on_q;

    always_comb begin
        sync_d = {sync_q[0], en_i};
        on_d   = sync_q[1];
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= sync_d;
    end

    always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) on_q <= 1'b0;
        else        on_q <= on_d;
    end

    assign clk_o = {WIDTH{clk_i & on_q}};
    assign on_o  = on_q;

endmodule

// File: rtl/clkctl_settle.sv
// Power-up settling counter in the reference clock domain.
module clkctl_settle #(
    parameter int SETTLE_CYCLES = 64
) (
    input  logic clk_ref_i,
    input  logic rst_n,
    input  logic req_i,
    output logic done_o
);

    localparam int CW = $clog2(SETTLE_CYCLES + 1);

    typedef struct packed {
        logic [1:0]    req_sync;
        logic [CW-1:0] cnt;
        logic          done;
    } settle_t;

    settle_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.req_sync = {st_q.req_sync[0], req_i};
        if (!st_q.req_sync[1]) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (!st_q.done) begin
            if (st_q.cnt == CW'(SETTLE_CYCLES - 1)) st_d.done = 1'b1;
            else                                    st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_ref_i or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;

endmodule

// File: rtl/clkctl_fsm.sv
// Stop and power sequencer on the PCI-rate clock.
module clkctl_fsm
    import clkctl_pkg::*;
#(
    parameter int DRAIN_CYCLES = 16
) (
    input  logic      clk_pci_i,
    input  logic      rst_n,
    input  logic      cpu_stop_n,
    input  logic      pci_stop_n,
    input  logic      pwr_dn_n,
    input  logic      settle_done_i,
    output logic      cpu_en_o,
    output logic      pci_en_o,
    output logic      base_en_o,
    output logic      osc_en_o,
    output logic      settle_req_o,
    output pm_state_e state_o
);

    localparam int DW = $clog2(DRAIN_CYCLES + 1);

    typedef struct packed {
        logic [1:0] cs_sync;
        logic [1:0] ps_sync;
        logic [1:0] pd_sync;
        logic [1:0] done_sync;
        pm_state_e  state;
        logic [DW-1:0] drain;
        logic       cpu_en;
        logic       pci_en;
        logic       base_en;
        logic       osc_en;
        logic       settle_req;
    } fsm_t;

    fsm_t      st_d, st_q;
    logic      cs_ok, ps_ok, pd_ok, settled, running;
    pm_state_e run_pick;

    always_comb begin
        st_d           = st_q;
        st_d.cs_sync   = {st_q.cs_sync[0], cpu_stop_n};
        st_d.ps_sync   = {st_q.ps_sync[0], pci_stop_n};
        st_d.pd_sync   = {st_q.pd_sync[0], pwr_dn_n};
        st_d.done_sync = {st_q.done_sync[0], settle_done_i};

        cs_ok   = st_q.cs_sync[1];
        ps_ok   = st_q.ps_sync[1];
        pd_ok   = st_q.pd_sync[1];
        settled = st_q.done_sync[1];

        // PCI stop outranks CPU stop in the reported state
        if (!ps_ok)      run_pick = ST_PCI_OFF;
        else if (!cs_ok) run_pick = ST_CPU_OFF;
        else             run_pick = ST_RUN;

        case (st_q.state)
            ST_RUN, ST_CPU_OFF, ST_PCI_OFF: begin
                if (!pd_ok) begin
                    st_d.state = ST_GOING_DOWN;
                    st_d.drain = '0;
                end else begin
                    st_d.state = run_pick;
                end
            end
            ST_GOING_DOWN: begin
                if (st_q.drain == DW'(DRAIN_CYCLES - 1)) st_d.state = ST_DOWN;
                else                                    st_d.drain = st_q.drain + 1'b1;
            end
            ST_DOWN: begin
                if (pd_ok && !settled) st_d.state = ST_WAKING;
            end
            ST_WAKING: begin
                if (!pd_ok) begin
                    st_d.state = ST_GOING_DOWN;
                    st_d.drain = '0;
                end else if (settled) begin
                    st_d.state = run_pick;
                end
            end
            default: st_d.state = ST_WAKING;
        endcase

        running = (st_d.state == ST_RUN) || (st_d.state == ST_CPU_OFF) ||
                  (st_d.state == ST_PCI_OFF);
        st_d.base_en    = running;
        st_d.cpu_en     = running && cs_ok;
        st_d.pci_en     = running && ps_ok;
        st_d.osc_en     = (st_d.state != ST_DOWN);
        st_d.settle_req = (st_d.state == ST_WAKING);
    end

    always_ff @(posedge clk_pci_i or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.cs_sync    <= 2'b11;
            st_q.ps_sync    <= 2'b11;
            st_q.pd_sync    <= 2'b11;
            st_q.state      <= ST_WAKING;
            st_q.osc_en     <= 1'b1;
            st_q.settle_req <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_en_o     = st_q.cpu_en;
    assign pci_en_o     = st_q.pci_en;
    assign base_en_o    = st_q.base_en;
    assign osc_en_o     = st_q.osc_en;
    assign settle_req_o = st_q.settle_req;
    assign state_o      = st_q.state;

endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
    import clkctl_pkg::*;
#(
    parameter int NUM_CPU       = 2,
    parameter int NUM_PCI       = 5,
    parameter int NUM_REF       = 2,
    parameter int DRAIN_CYCLES  = 16,
    parameter int SETTLE_CYCLES = 64
) (
    input  logic               clk_cpu_i,
    input  logic               clk_pci_i,
    input  logic               clk_48_i,
    input  logic               clk_48_24_i,
    input  logic               clk_ref_i,
    input  logic               rst_n,
    input  logic               cpu_stop_n,
    input  logic               pci_stop_n,
    input  logic               pwr_dn_n,
    output logic [NUM_CPU-1:0] cpu_clk_o,
    output logic [NUM_PCI-1:0] pci_clk_o,
    output logic               pcif_clk_o,
    output logic               clk48_o,
    output logic               clk48_24_o,
    output logic [NUM_REF-1:0] ref_clk_o,
    output logic               osc_en_o,
    output logic               vco_en_o,
    output logic [2:0]         state_o
);

    localparam int NUM_GATES = 6;

    logic            cpu_en, pci_en, base_en, osc_en, settle_req, settle_done;
    pm_state_e       state;
    logic [NUM_GATES-1:0] gate_on;

    clkctl_fsm #(.DRAIN_CYCLES(DRAIN_CYCLES)) fsm_i (
        .clk_pci_i    (clk_pci_i),
        .rst_n        (rst_n),
        .cpu_stop_n   (cpu_stop_n),
        .pci_stop_n   (pci_stop_n),
        .pwr_dn_n     (pwr_dn_n),
        .settle_done_i(settle_done),
        .cpu_en_o     (cpu_en),
        .pci_en_o     (pci_en),
        .base_en_o    (base_en),
        .osc_en_o     (osc_en),
        .settle_req_o (settle_req),
        .state_o      (state)
    );

    clkctl_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) settle_i (
        .clk_ref_i(clk_ref_i),
        .rst_n    (rst_n),
        .req_i    (settle_req),
        .done_o   (settle_done)
    );

    clkctl_gate #(.WIDTH(NUM_CPU)) cpu_gate_i (
        .clk_i(clk_cpu_i), .rst_n(rst_n), .en_i(cpu_en),
        .clk_o(cpu_clk_o), .on_o(gate_on[0])
    );

    clkctl_gate #(.WIDTH(NUM_PCI)) pci_gate_i (
        .clk_i(clk_pci_i), .rst_n(rst_n), .en_i(pci_en),
        .clk_o(pci_clk_o), .on_o(gate_on[1])
    );

    clkctl_gate #(.WIDTH(1)) pcif_gate_i (
        .clk_i(clk_pci_i), .rst_n(rst_n), .en_i(base_en),
        .clk_o(pcif_clk_o), .on_o(gate_on[2])
    );

    clkctl_gate #(.WIDTH(1)) c48_gate_i (
        .clk_i(clk_48_i), .rst_n(rst_n), .en_i(base_en),
        .clk_o(clk48_o), .on_o(gate_on[3])
    );

    clkctl_gate #(.WIDTH(1)) c4824_gate_i (
        .clk_i(clk_48_24_i), .rst_n(rst_n), .en_i(base_en),
        .clk_o(clk48_24_o), .on_o(gate_on[4])
    );

    clkctl_gate #(.WIDTH(NUM_REF)) ref_gate_i (
        .clk_i(clk_ref_i), .rst_n(rst_n), .en_i(base_en),
        .clk_o(ref_clk_o), .on_o(gate_on[5])
    );

    assign osc_en_o = osc_en;
    assign vco_en_o = osc_en;
    assign state_o  = state;

endmodule

// File: rtl/clkctl_top_chk.sv
module clkctl_top_chk (
    input logic       clk_pci_i,
    input logic       clk_cpu_i,
    input logic       rst_n,
    input logic [2:0] state_o,
    input logic       osc_en_o,
    input logic       vco_en_o,
    input logic [5:0] gate_on
);

    // R1
    down_quiet_chk: assert property (@(posedge clk_pci_i) disable iff (!rst_n)
        (state_o == 3'd4) |-> (!osc_en_o && !vco_en_o && gate_on == 6'd0));

    // R7
    drop_after_gates_chk: assert property (@(posedge clk_pci_i) disable iff (!rst_n)
        $fell(osc_en_o) |-> (gate_on == 6'd0));

    // R7
    drop_from_drain_chk: assert property (@(posedge clk_pci_i) disable iff (!rst_n)
        $fell(vco_en_o) |-> ($past(state_o) == 3'd3));

    // R8
    wake_osc_chk: assert property (@(posedge clk_pci_i) disable iff (!rst_n)
        (state_o == 3'd5) |-> (osc_en_o && vco_en_o));

    // R5
    always @(gate_on[0]) begin
        if (rst_n) cpu_gate_low_chk: assert (clk_cpu_i == 1'b0);
    end

    // R5
    always @(gate_on[1]) begin
        if (rst_n) pci_gate_low_chk: assert (clk_pci_i == 1'b0);
    end

endmodule

bind clkctl_top clkctl_top_chk chk_i (
    .clk_pci_i(clk_pci_i),
    .clk_cpu_i(clk_cpu_i),
    .rst_n    (rst_n),
    .state_o  (state_o),
    .osc_en_o (osc_en_o),
    .vco_en_o (vco_en_o),
    .gate_on  (gate_on)
);

// File: tb/clkctl_top_tb_top.sv
module clkctl_top_tb_top;

    localparam int NCPU = 2, NPCI = 5, NREF = 2, SETTLE = 64, REF_PER = 70;

    logic clk_cpu = 0, clk_pci = 0, clk_48 = 0, clk_4824 = 0, clk_ref = 0;
    logic rst_n, cs_n, ps_n, pd_n;
    logic [NCPU-1:0] cpu_clk;
    logic [NPCI-1:0] pci_clk;
    logic [NREF-1:0] ref_clk;
    logic pcif_clk, c48, c4824, osc_en, vco_en;
    logic [2:0] state;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    always #5  clk_cpu  = ~clk_cpu;
    always #10 clk_pci  = ~clk_pci;   // 50 MHz
    always #11 clk_48   = ~clk_48;
    always #22 clk_4824 = ~clk_4824;
    always #35 clk_ref  = ~clk_ref;

    clkctl_top #(.NUM_CPU(NCPU), .NUM_PCI(NPCI), .NUM_REF(NREF),
                 .DRAIN_CYCLES(16), .SETTLE_CYCLES(SETTLE)) dut_i (
        .clk_cpu_i(clk_cpu), .clk_pci_i(clk_pci), .clk_48_i(clk_48),
        .clk_48_24_i(clk_4824), .clk_ref_i(clk_ref), .rst_n(rst_n),
        .cpu_stop_n(cs_n), .pci_stop_n(ps_n), .pwr_dn_n(pd_n),
        .cpu_clk_o(cpu_clk), .pci_clk_o(pci_clk), .pcif_clk_o(pcif_clk),
        .clk48_o(c48), .clk48_24_o(c4824), .ref_clk_o(ref_clk),
        .osc_en_o(osc_en), .vco_en_o(vco_en), .state_o(state)
    );

    logic any_out;
    assign any_out = |{cpu_clk, pci_clk, pcif_clk, c48, c4824, ref_clk};

    // pulse width monitors (R5)
    realtime cpu_rise = 0, pci_rise = 0, last_fall = 0;
    int runts = 0;
    always @(posedge cpu_clk[0]) cpu_rise = $realtime;
    always @(negedge cpu_clk[0]) if ($realtime - cpu_rise < 4.5) runts++;
    always @(posedge pci_clk[0]) pci_rise = $realtime;
    always @(negedge pci_clk[0]) if ($realtime - pci_rise < 9.5) runts++;
    always @(negedge any_out) last_fall = $realtime;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // bit order: cpu, pci, pcif, 48, 48/24, ref
    task automatic observe(input int dur, output logic [5:0] hi);
        hi = '0;
        for (int i = 0; i < dur; i++) begin
            #1;
            hi |= {|ref_clk, c4824, c48, pcif_clk, |pci_clk, |cpu_clk};
        end
    endtask

    function automatic logic [5:0] exp_hi(input logic cs, input logic ps);
        return {1'b1, 1'b1, 1'b1, 1'b1, ps, cs};
    endfunction

    function automatic int exp_state(input logic cs, input logic ps);
        if (!ps) return 2;
        if (!cs) return 1;
        return 0;
    endfunction

    task automatic wait_run(input string req, input realtime t0);
        int guard = 0;
        while (state != 3'd0 && guard < 20000) begin #1; guard++; end
        chk(state == 3'd0, req, "reaches RUN after settling", int'(state), 0);
        chk(($realtime - t0) >= SETTLE * REF_PER, req, "settle interval length",
            int'($realtime - t0), SETTLE * REF_PER);
    endtask

    task automatic run_case(input logic cs, input logic ps, input string req);
        logic [5:0] hi;
        cs_n = cs; ps_n = ps;
        #300;
        chk(int'(state) == exp_state(cs, ps), req, "state code", int'(state), exp_state(cs, ps));
        observe(300, hi);
        chk(hi == exp_hi(cs, ps), req, "output activity", int'(hi), int'(exp_hi(cs, ps)));
    endtask

    initial begin
        logic [5:0] hi;
        realtime t0, tpd;
        int guard;
        void'($urandom(32'd4711));
        rst_n = 0; cs_n = 1; ps_n = 1; pd_n = 1;
        #103 rst_n = 1;
        t0 = $realtime;
        #2;
        // R9 reset state
        chk(state == 3'd5, "R9", "state after reset", int'(state), 5);
        chk(osc_en && vco_en, "R9", "enables after reset", int'({osc_en, vco_en}), 3);
        observe(500, hi);
        chk(hi == 6'd0, "R9", "outputs low after reset", int'(hi), 0);
        wait_run("R8", t0);

        // R4 all running, and both stops
        run_case(1, 1, "R4");
        run_case(0, 0, "R4");
        run_case(0, 1, "R2");
        run_case(1, 0, "R3");
        for (int k = 0; k < 16; k++) begin
            logic cs, ps;
            cs = 1'($urandom_range(0, 1));
            ps = 1'($urandom_range(0, 1));
            run_case(cs, ps, !ps ? "R3" : (!cs ? "R2" : "R4"));
        end

        // R6 CPU stop/start latency
        run_case(1, 1, "R6");
        @(posedge clk_pci); #3;
        cs_n = 0;
        observe(30, hi);
        chk(hi[0], "R6", "cpu still toggles just after stop edge", int'(hi[0]), 1);
        #70;
        observe(100, hi);
        chk(!hi[0], "R6", "cpu parked within latency bound", int'(hi[0]), 0);
        cs_n = 1;
        observe(30, hi);
        chk(!hi[0], "R6", "cpu still parked just after start edge", int'(hi[0]), 0);
        #70;
        observe(100, hi);
        chk(hi[0], "R6", "cpu running within latency bound", int'(hi[0]), 1);

        // R7 power-down ordering
        cs_n = 1'($urandom_range(0, 1));
        ps_n = 1'($urandom_range(0, 1));
        pd_n = 0;
        tpd = $realtime;
        #100;
        chk(state == 3'd3, "R7", "draining state", int'(state), 3);
        chk(osc_en == 1'b1, "R7", "oscillator still on while draining", int'(osc_en), 1);
        guard = 0;
        while (osc_en && guard < 5000) begin #1; guard++; end
        chk(!osc_en && !vco_en, "R7", "enables dropped", int'({osc_en, vco_en}), 0);
        chk(!any_out && ($realtime - last_fall) >= 100.0, "R7",
            "outputs quiet before enables drop", int'($realtime - last_fall), 100);

        // R1 down, stops toggled meanwhile
        cs_n = ~cs_n;
        #100;
        ps_n = ~ps_n;
        #100;
        chk(state == 3'd4, "R1", "state DOWN", int'(state), 4);
        observe(400, hi);
        chk(hi == 6'd0, "R1", "all outputs low in power down", int'(hi), 0);
        chk(!vco_en, "R1", "VCO off in power down", int'(vco_en), 0);

        // R8 wake
        cs_n = 1; ps_n = 1;
        pd_n = 1;
        t0 = $realtime;
        #200;
        chk(state == 3'd5, "R8", "state POWERING_UP", int'(state), 5);
        chk(osc_en && vco_en, "R8", "enables on while settling", int'({osc_en, vco_en}), 3);
        observe(1500, hi);
        chk(hi == 6'd0, "R8", "outputs low while settling", int'(hi), 0);
        wait_run("R8", t0);
        run_case(1, 1, "R8");

        // R5 stop/start sweep then pulse width check
        for (int k = 0; k < 8; k++) begin
            cs_n = ~cs_n; #(37 + k * 13);
            ps_n = ~ps_n; #(41 + k * 7);
        end
        cs_n = 1; ps_n = 1;
        #300;
        chk(runts == 0, "R5", "no short high pulses", runts, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule